// File: doc/BRIEF.md
# Thirty-Cent Change-Making Vending Controller

This block is the control core of a drink dispenser that sells every can for 30 cents. Each clock cycle it may receive a one-cycle pulse reporting that a quarter, a dime or a nickel was inserted. It adds the value to a running credit. Once the credit reaches 30 cents or more, it pulses the can dispenser for one cycle. It then pays back any excess one coin per clock, using dimes while at least 10 cents are owed and a nickel for a final 5.

The machine has 15 explicit states: idle, ten credit states from 5 to 50 cents in 5-cent steps, and four payback states for 20, 15, 10 and 5 cents still owed. All outputs are decoded from the registered state only, so each strobe appears in the cycle after the clock edge that produced that state. A parameter selects how the state register is encoded. With binary encoding the state is a 4-bit index from 0 to 14. With one-hot encoding it is a 16-bit vector in which idle is bit 0. The behaviour at the ports is the same for both encodings.

Top module: `coin_vend_ctrl`

## Requirements
- R1: While the credit is below 30 cents, a pulse on coinNickel, coinDime or coinQuarter adds 5, 10 or 25 cents to the credit, and a cycle with no coin pulse leaves the credit unchanged.
- R2: In the cycle after the clock edge on which the credit reaches 30 cents or more, dispenseCan is high for exactly one cycle.
- R3: After the can, the excess is paid on consecutive cycles, one strobe per cycle: a dispenseDime strobe while 10 or more cents are owed and a dispenseNickel strobe for a last 5 cents. For example, 20 cents owed gives dime, dime, and 15 cents owed gives dime, nickel.
- R4: At most one of dispenseCan, dispenseDime and dispenseNickel is high in any cycle.
- R5: A coin pulse that arrives while dispenseCan, dispenseDime or dispenseNickel is high is ignored and adds no credit.
- R6: The reset is synchronous. After a clock edge with rst high the machine is idle with zero credit and all three outputs low, including when the reset arrives in the middle of a credit or a payback.
- R7: Parameter OneHot=0 uses a 4-bit binary state from 0 to 14, and OneHot=1 uses a 16-bit one-hot state with idle on bit 0. Both give identical port behaviour.
- R8: For every vend, the accepted coins equal 30 cents plus the total change that is paid out.
- R9: A credit of exactly 30 cents dispenses the can, pays no change and returns to idle in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| coinQuarter | input | 1 | One-cycle pulse: a 25-cent coin was inserted |
| coinDime | input | 1 | One-cycle pulse: a 10-cent coin was inserted |
| coinNickel | input | 1 | One-cycle pulse: a 5-cent coin was inserted |
| dispenseCan | output | 1 | One-cycle strobe: release one can |
| dispenseDime | output | 1 | One-cycle strobe: pay back one dime |
| dispenseNickel | output | 1 | One-cycle strobe: pay back one nickel |

## Verification
The bench builds two copies of the block side by side, one with OneHot=0 and one with OneHot=1, and drives both with the same inputs. Every output of the two copies is compared on every cycle. This exposes any difference between the binary and one-hot state registers under the same coin traffic. The long random run uses the one-hot copy to check, for each vend, that the accepted coins equal the price plus the change paid. It also checks in every cycle that at most one output is high.

// File: rtl/vend_pkg.sv
package vend_pkg;
  // Abstract state index; binary encoding uses these values directly.
  localparam int NumStates = 15;
  localparam int IdxW      = 4;
  localparam int OneHotW   = 16;

  localparam logic [IdxW-1:0] IdxIdle   = 4'd0;   // 0 cents
  localparam logic [IdxW-1:0] IdxLast   = 4'd5;   // 25 cents, last state below price
  localparam logic [IdxW-1:0] IdxPrice  = 4'd6;   // exactly 30 cents
  localparam logic [IdxW-1:0] IdxTop    = 4'd10;  // 50 cents
  localparam logic [IdxW-1:0] IdxOwe20  = 4'd11;
  localparam logic [IdxW-1:0] IdxOwe15  = 4'd12;
  localparam logic [IdxW-1:0] IdxOwe10  = 4'd13;
  localparam logic [IdxW-1:0] IdxOwe5   = 4'd14;

  // Coin steps in units of 5 cents
  localparam logic [IdxW-1:0] StepQuarter = 4'd5;
  localparam logic [IdxW-1:0] StepDime    = 4'd2;
  localparam logic [IdxW-1:0] StepNickel  = 4'd1;

  // Control-to-datapath command: output strobes plus the next abstract state
  typedef struct packed {
    logic            can;
    logic            dime;
    logic            nickel;
    logic [IdxW-1:0] nextIdx;
  } vendCmd_t;
endpackage

// File: rtl/vend_state_reg.sv
module vend_state_reg
  import vend_pkg::*;
#(
  parameter bit OneHot = 1'b0
) (
  input  logic            clk,
  input  logic            rst,
  input  vendCmd_t        cmd,
  output logic [IdxW-1:0] stateIdx
);
  localparam int CodeW = OneHot ? OneHotW : IdxW;

  logic [CodeW-1:0] stateQ;
  logic [CodeW-1:0] nextCode;
  logic [CodeW-1:0] idleCode;

  generate
    if (OneHot) begin : g_onehot
      assign idleCode = CodeW'(1);
      assign nextCode = CodeW'(1) << cmd.nextIdx;
      always_comb begin
        stateIdx = IdxIdle;
        for (int i = 0; i < NumStates; i++) begin
          if (stateQ[i]) stateIdx = IdxW'(i);
        end
      end
      // R7: exactly one hot bit, never the spare top bit
      p_legal_code_r7: assert property (@(posedge clk) disable iff (rst)
        $onehot(stateQ) && !stateQ[CodeW-1]);
    end else begin : g_binary
      assign idleCode = '0;
      assign nextCode = cmd.nextIdx;
      assign stateIdx = stateQ;
      // R7: binary code stays within the 15 defined states
      p_legal_code_r7: assert property (@(posedge clk) disable iff (rst)
        stateQ < CodeW'(NumStates));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) stateQ <= idleCode;
    else     stateQ <= nextCode;
  end

  // R6: a reset edge always lands in idle
  p_reset_idle_r6: assert property (@(posedge clk)
    rst |=> stateIdx == IdxIdle);
endmodule

// File: rtl/vend_ctrl.sv
module vend_ctrl
  import vend_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [IdxW-1:0] stateIdx,
  input  logic            coinQuarter,
  input  logic            coinDime,
  input  logic            coinNickel,
  output vendCmd_t        cmd
);
  logic [IdxW-1:0] step;

  always_comb begin
    if (coinQuarter)     step = StepQuarter;
    else if (coinDime)   step = StepDime;
    else if (coinNickel) step = StepNickel;
    else                 step = '0;
  end

  always_comb begin
    cmd         = '0;
    cmd.nextIdx = IdxIdle;
    if (stateIdx <= IdxLast) begin
      cmd.nextIdx = stateIdx + step;
    end else if (stateIdx <= IdxTop) begin
      cmd.can = 1'b1;
      // 30 -> idle, 35..50 -> owe 5..20 (coins ignored)
      cmd.nextIdx = (stateIdx == IdxPrice) ? IdxIdle : IdxW'(21) - stateIdx;
    end else begin
      unique case (stateIdx)
        IdxOwe20: begin cmd.dime   = 1'b1; cmd.nextIdx = IdxOwe10; end
        IdxOwe15: begin cmd.dime   = 1'b1; cmd.nextIdx = IdxOwe5;  end
        IdxOwe10: begin cmd.dime   = 1'b1; cmd.nextIdx = IdxIdle;  end
        IdxOwe5:  begin cmd.nickel = 1'b1; cmd.nextIdx = IdxIdle;  end
        default:  cmd.nextIdx = IdxIdle;
      endcase
    end
  end

  // R4: never two output strobes together
  p_one_strobe_r4: assert property (@(posedge clk) disable iff (rst)
    $onehot0({cmd.can, cmd.dime, cmd.nickel}));
  // R2: the can strobe lasts a single cycle
  p_can_single_r2: assert property (@(posedge clk) disable iff (rst)
    cmd.can |=> !cmd.can);
  // R3: owing 20 pays a dime and then still owes 10
  p_owe20_r3: assert property (@(posedge clk) disable iff (rst)
    stateIdx == IdxOwe20 |=> stateIdx == IdxOwe10);
  // R3: a nickel is always the last coin of a payback
  p_nickel_last_r3: assert property (@(posedge clk) disable iff (rst)
    cmd.nickel |=> stateIdx == IdxIdle);
  // R5, R9: exactly 30 returns to idle whatever coin is present
  p_price_exit_r9: assert property (@(posedge clk) disable iff (rst)
    stateIdx == IdxPrice |=> stateIdx == IdxIdle);
endmodule

// File: rtl/coin_vend_ctrl.sv
module coin_vend_ctrl
  import vend_pkg::*;
#(
  parameter bit OneHot = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic coinQuarter,
  input  logic coinDime,
  input  logic coinNickel,
  output logic dispenseCan,
  output logic dispenseDime,
  output logic dispenseNickel
);
  vendCmd_t        cmd;
  logic [IdxW-1:0] stateIdx;

  vend_ctrl u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .stateIdx    (stateIdx),
    .coinQuarter (coinQuarter),
    .coinDime    (coinDime),
    .coinNickel  (coinNickel),
    .cmd         (cmd)
  );

  vend_state_reg #(.OneHot(OneHot)) u_state (
    .clk      (clk),
    .rst      (rst),
    .cmd      (cmd),
    .stateIdx (stateIdx)
  );

  assign dispenseCan    = cmd.can;
  assign dispenseDime   = cmd.dime;
  assign dispenseNickel = cmd.nickel;
endmodule

// File: tb/coin_vend_ctrl_tb.sv
`timescale 1ns/1ps
module coin_vend_ctrl_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic coinQuarter = 1'b0, coinDime = 1'b0, coinNickel = 1'b0;
  logic canB, dimeB, nickB, canH, dimeH, nickH;
  int totalCnt = 0;
  int failCnt  = 0;

  always #5 clk = ~clk;

  coin_vend_ctrl #(.OneHot(1'b0)) u_dut (
    .clk(clk), .rst(rst), .coinQuarter(coinQuarter), .coinDime(coinDime),
    .coinNickel(coinNickel), .dispenseCan(canB), .dispenseDime(dimeB),
    .dispenseNickel(nickB));

  coin_vend_ctrl #(.OneHot(1'b1)) u_dutOh (
    .clk(clk), .rst(rst), .coinQuarter(coinQuarter), .coinDime(coinDime),
    .coinNickel(coinNickel), .dispenseCan(canH), .dispenseDime(dimeH),
    .dispenseNickel(nickH));

  // Row = {coin[1:0], can, dime, nickel}; coin 0 none, 1 nickel, 2 dime, 3 quarter.
  // Outputs are those seen after the edge that captures the row's coin.
  localparam int NVec = 42;
  localparam logic [4:0] VecTbl [NVec] = '{
    5'b11000, 5'b01100, 5'b00000,                                 // 25+5
    5'b11000, 5'b11100, 5'b00010, 5'b00010, 5'b00000,             // 50: two dimes
    5'b10000, 5'b10000, 5'b10100, 5'b00000,                       // 3 dimes
    5'b10000, 5'b11100, 5'b11001, 5'b10000, 5'b01000, 5'b11100, 5'b00000, // 35, ignored coins
    5'b10000, 5'b10000, 5'b11100, 5'b00010, 5'b00001, 5'b00000,   // 45: dime, nickel
    5'b10000, 5'b01000, 5'b11100, 5'b00010, 5'b00000,             // 40: dime
    5'b01000, 5'b00000, 5'b00000, 5'b11100, 5'b00000,             // hold, then quarter
    5'b01000, 5'b01000, 5'b01000, 5'b01000, 5'b01000, 5'b01100, 5'b00000 // six nickels
  };

  task automatic check(input bit ok, input string req, input logic [2:0] act,
                       input logic [2:0] exp);
    totalCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s: outputs {can,dime,nickel} actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic driveCoin(input logic [1:0] c);
    coinNickel  = (c == 2'd1);
    coinDime    = (c == 2'd2);
    coinQuarter = (c == 2'd3);
  endtask

  task automatic stepCheck(input logic [1:0] c, input logic [2:0] exp, input string req);
    driveCoin(c);
    @(negedge clk);
    check({canB, dimeB, nickB} == exp, req, {canB, dimeB, nickB}, exp);
    check({canH, dimeH, nickH} == exp, {req, " R7 one-hot"}, {canH, dimeH, nickH}, exp);
  endtask

  initial begin
    #2000000;
    failCnt++;
    totalCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", totalCnt - failCnt, totalCnt);
    $finish;
  end

  initial begin
    int accum, paid, vendCredit;
    bit inVend;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R6: reset state
    check({canB, dimeB, nickB} == 3'b000, "R6 reset state", {canB, dimeB, nickB}, 3'b000);
    check({canH, dimeH, nickH} == 3'b000, "R6 reset state R7", {canH, dimeH, nickH}, 3'b000);

    // Table walk: R1 credit, R2 can, R3 change, R5 ignored coins, R9 exact price
    for (int i = 0; i < NVec; i++)
      stepCheck(VecTbl[i][4:3], VecTbl[i][2:0], "table R1 R2 R3 R5 R9");

    // R6: reset mid-credit discards the quarter
    stepCheck(2'd3, 3'b000, "R6 pre");
    rst = 1'b1;
    stepCheck(2'd0, 3'b000, "R6 reset mid-credit");
    rst = 1'b0;
    stepCheck(2'd1, 3'b000, "R6 after reset");
    stepCheck(2'd3, 3'b100, "R6 credit restarted at 5");
    stepCheck(2'd0, 3'b000, "R9 back to idle");

    // R6: reset during payback suppresses the change
    stepCheck(2'd3, 3'b000, "R6 pre");
    stepCheck(2'd3, 3'b100, "R2 can at 50");
    rst = 1'b1;
    stepCheck(2'd0, 3'b000, "R6 reset during payback");
    rst = 1'b0;
    stepCheck(2'd0, 3'b000, "R6 stays idle");
    stepCheck(2'd2, 3'b000, "R1 fresh credit");
    stepCheck(2'd2, 3'b000, "R1 fresh credit");
    stepCheck(2'd2, 3'b100, "R9 exact price");
    stepCheck(2'd0, 3'b000, "R9 no change");

    // Random traffic: R8 conservation per vend, R4 single strobe, R7 equivalence
    accum = 0; paid = 0; vendCredit = 0; inVend = 0;
    for (int n = 0; n < 4000; n++) begin
      logic [1:0] c;
      int pick;
      if ({canH, dimeH, nickH} != {canB, dimeB, nickB})
        check(1'b0, "R7 encodings differ", {canH, dimeH, nickH}, {canB, dimeB, nickB});
      if ($countones({canH, dimeH, nickH}) > 1)
        check(1'b0, "R4 two strobes", {canH, dimeH, nickH}, 3'b000);
      if (canH) begin
        vendCredit = accum; paid = 0; inVend = 1;
      end
      if (dimeH) paid += 10;
      if (nickH) paid += 5;
      if ({canH, dimeH, nickH} == 3'b000 && inVend) begin
        check(paid == vendCredit - 30, "R8 coins in equal 30 plus change",
              3'(paid / 5), 3'((vendCredit - 30) / 5));
        inVend = 0; accum = 0;
      end
      pick = $urandom_range(0, 5);
      c = (pick > 3) ? 2'd0 : 2'(pick);
      if ({canH, dimeH, nickH} == 3'b000)
        accum += (c == 2'd1) ? 5 : (c == 2'd2) ? 10 : (c == 2'd3) ? 25 : 0;
      driveCoin(c);
      @(negedge clk);
    end
    totalCnt++;  // R4 and R7 per-cycle scan counted as one check
    driveCoin(2'd0);
    $display("%0d/%0d checks passed", totalCnt - failCnt, totalCnt);
    $finish;
  end
endmodule